// File: doc/BRIEF.md
# Asynchronous Static RAM Host Bridge

This block lets a clocked host read and write an external asynchronous static RAM with a 17-bit word address and an 8-bit data bus. The host presents one request at a time through a valid/ready handshake carrying a direction flag, an address and write data. Reads return data with a one-cycle valid pulse. On the memory side the block drives three active-low strobes (select, output enable, write strobe), the address, and a data driver with a separate enable that forms the tri-state bus. The bus value driven by the memory arrives on its own input.

Each phase of an access is held for a whole number of clock cycles. The cycle count is derived from a clock-period parameter and a set of nanosecond timing limits, rounded up, with at least one cycle per phase. Writes are closed by the write strobe rising while select is still low. Write data is only driven once a turnaround interval has passed after the write strobe falls. After reset, no access starts until a power-up interval has elapsed.

Top module: `asram_host_bridge`

## Requirements
- R1: While reset is asserted, select, output enable and write strobe are all high, the data driver is off and ready is low.
- R2: After reset is released, ready stays low and requests are ignored for exactly ceil(T_PWRUP_NS / CLK_NS) rising edges (10000 at defaults). The memory strobes stay high throughout.
- R3: A request is accepted only on an edge where ready is high. Ready is low from the acceptance edge until the access completes. A request presented while ready is low has no effect on the memory.
- R4: A read holds select and output enable low and the write strobe high for ceil(max(read cycle, access time) / CLK_NS) cycles (1 at defaults). Data is captured at the last edge of that window. It appears on rspData with rspValid high for exactly one cycle, starting at that edge.
- R5: A write holds select and the write strobe low with output enable high. The write strobe rises one cycle before select does.
- R6: After the write strobe falls, the data driver stays off for ceil(T_HZ_NS / CLK_NS) cycles (1 at defaults). It then drives the latched write data until select rises.
- R7: The write strobe stays low for at least max(pulse width, select-to-end, write cycle minus one cycle, turnaround plus data setup) rounded up to cycles (2 at defaults). Write data is driven for at least ceil(T_SD_NS / CLK_NS) cycles before the write strobe rises.
- R8: The data driver is never on while output enable is low, and it is only on while select is low.
- R9: The address does not change while select stays low.
- R10: After every access, the block returns for at least one cycle to idle: all strobes high, driver off, ready high.
- R11: Asserting reset in the middle of an access forces the idle strobe state at once, aborts the access, and restarts the full power-up interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Block can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | 17 | Word address |
| reqWdata | input | 8 | Write data |
| rspValid | output | 1 | One-cycle pulse, read data valid |
| rspData | output | 8 | Read data |
| memCeN | output | 1 | Memory select, active low |
| memOeN | output | 1 | Memory output enable, active low |
| memWeN | output | 1 | Memory write strobe, active low |
| memAddr | output | 17 | Memory address |
| memDqOut | output | 8 | Data driven toward memory |
| memDqOe | output | 1 | Data driver enable (1 = drive) |
| memDqIn | input | 8 | Data received from memory bus |

## Verification
At default timing, a read accepted at edge N shows its strobes after edge N. Its data and valid pulse appear after edge N+1, and the pulse is gone after edge N+2. A write accepted at edge N has its strobes low with the driver off after N, data driven after N+1, the write strobe back high after N+2, and full idle with ready after N+3. The power-up interval is counted edge by edge until ready rises. The bench applies inputs and samples outputs on falling edges, so each check lands in the half-cycle after the edge where the result is due. A behavioural memory model in the bench stores data on the write strobe's rising edge and drives read data only while reads are enabled, so stored contents are checked end to end.

// File: rtl/asram_bridge_pkg.sv
package asram_bridge_pkg;

  typedef enum logic [2:0] {
    ST_PWRUP,
    ST_IDLE,
    ST_READ,
    ST_WTURN,
    ST_WDATA,
    ST_WHOLD
  } bridgeState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic ceN;     // registered pin value
    logic oeN;     // registered pin value
    logic weN;     // registered pin value
    logic dqOe;    // registered pin value
    logic load;    // capture host request this edge
    logic sample;  // capture read data this edge
  } bridgeStb_t;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  // nanoseconds to cycles, rounded up, never below one
  function automatic int ns2cyc(input int ns, input int clkNs);
    return imax(1, (ns + clkNs - 1) / clkNs);
  endfunction

endpackage

// File: rtl/asram_bridge_ctrl.sv
module asram_bridge_ctrl
  import asram_bridge_pkg::*;
#(
  parameter int CLK_NS     = 10,
  parameter int T_RC_NS    = 10,
  parameter int T_AA_NS    = 10,
  parameter int T_HZ_NS    = 5,
  parameter int T_SD_NS    = 5,
  parameter int T_PWE_NS   = 7,
  parameter int T_SCE_NS   = 8,
  parameter int T_AWE_NS   = 8,
  parameter int T_WC_NS    = 10,
  parameter int T_PWRUP_NS = 100000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       reqWrite,
  output logic       reqReady,
  output bridgeStb_t stb
);

  localparam int RD_CYC   = ns2cyc(imax(T_RC_NS, T_AA_NS), CLK_NS);
  localparam int TURN_CYC = ns2cyc(T_HZ_NS, CLK_NS);
  localparam int WE_MIN   = ns2cyc(imax(T_PWE_NS, imax(T_SCE_NS, T_AWE_NS)), CLK_NS);
  localparam int WE_CYC   = imax(imax(WE_MIN, TURN_CYC + ns2cyc(T_SD_NS, CLK_NS)),
                                 ns2cyc(T_WC_NS, CLK_NS) - 1);
  localparam int DATA_CYC = WE_CYC - TURN_CYC;
  localparam int PWR_CYC  = ns2cyc(T_PWRUP_NS, CLK_NS);
  localparam int CNT_W    = $clog2(imax(imax(PWR_CYC, RD_CYC), WE_CYC) + 1);

  bridgeState_t state, nxtState;
  logic [CNT_W-1:0] cnt, nxtCnt;
  logic load, sample;
  logic ceQ, oeQ, weQ, dqOeQ;
  logic cntZero;

  assign cntZero = (cnt == '0);

  always_comb begin
    nxtState = state;
    nxtCnt   = cnt;
    load     = 1'b0;
    sample   = 1'b0;
    unique case (state)
      ST_PWRUP: begin
        if (cntZero) nxtState = ST_IDLE;
        else         nxtCnt   = cnt - 1'b1;
      end
      ST_IDLE: begin
        if (reqValid) begin
          load = 1'b1;
          if (reqWrite) begin
            nxtState = ST_WTURN;
            nxtCnt   = CNT_W'(TURN_CYC - 1);
          end else begin
            nxtState = ST_READ;
            nxtCnt   = CNT_W'(RD_CYC - 1);
          end
        end
      end
      ST_READ: begin
        if (cntZero) begin
          sample   = 1'b1;
          nxtState = ST_IDLE;
        end else nxtCnt = cnt - 1'b1;
      end
      ST_WTURN: begin
        if (cntZero) begin
          nxtState = ST_WDATA;
          nxtCnt   = CNT_W'(DATA_CYC - 1);
        end else nxtCnt = cnt - 1'b1;
      end
      ST_WDATA: begin
        if (cntZero) nxtState = ST_WHOLD;
        else         nxtCnt   = cnt - 1'b1;
      end
      ST_WHOLD: nxtState = ST_IDLE;
      default:  nxtState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= ST_PWRUP;
      cnt   <= CNT_W'(PWR_CYC - 1);
      ceQ   <= 1'b1;
      oeQ   <= 1'b1;
      weQ   <= 1'b1;
      dqOeQ <= 1'b0;
    end else begin
      state <= nxtState;
      cnt   <= nxtCnt;
      // pins registered from the next state: glitch-free at the memory
      ceQ   <= !(nxtState inside {ST_READ, ST_WTURN, ST_WDATA, ST_WHOLD});
      oeQ   <= (nxtState != ST_READ);
      weQ   <= !(nxtState inside {ST_WTURN, ST_WDATA});
      dqOeQ <= (nxtState inside {ST_WDATA, ST_WHOLD});
    end
  end

  assign reqReady = (state == ST_IDLE);

  assign stb = '{ceN: ceQ, oeN: oeQ, weN: weQ, dqOe: dqOeQ,
                 load: load, sample: sample};

endmodule

// File: rtl/asram_bridge_dp.sv
module asram_bridge_dp
  import asram_bridge_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bridgeStb_t        stb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [DATA_W-1:0] memDqIn,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData
);

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] wdataQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ    <= '0;
      wdataQ   <= '0;
      rspValid <= 1'b0;
      rspData  <= '0;
    end else begin
      if (stb.load) begin
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      rspValid <= stb.sample;
      if (stb.sample) rspData <= memDqIn;
    end
  end

  assign memCeN   = stb.ceN;
  assign memOeN   = stb.oeN;
  assign memWeN   = stb.weN;
  assign memDqOe  = stb.dqOe;
  assign memAddr  = addrQ;
  assign memDqOut = wdataQ;

endmodule

// File: rtl/asram_host_bridge.sv
module asram_host_bridge
  import asram_bridge_pkg::*;
#(
  parameter int ADDR_W     = 17,
  parameter int DATA_W     = 8,
  parameter int CLK_NS     = 10,
  parameter int T_RC_NS    = 10,
  parameter int T_AA_NS    = 10,
  parameter int T_HZ_NS    = 5,
  parameter int T_SD_NS    = 5,
  parameter int T_PWE_NS   = 7,
  parameter int T_SCE_NS   = 8,
  parameter int T_AWE_NS   = 8,
  parameter int T_WC_NS    = 10,
  parameter int T_PWRUP_NS = 100000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  output logic              rspValid,
  output logic [DATA_W-1:0] rspData,
  output logic              memCeN,
  output logic              memOeN,
  output logic              memWeN,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memDqOut,
  output logic              memDqOe,
  input  logic [DATA_W-1:0] memDqIn
);

  bridgeStb_t stb;

  asram_bridge_ctrl #(
    .CLK_NS(CLK_NS), .T_RC_NS(T_RC_NS), .T_AA_NS(T_AA_NS), .T_HZ_NS(T_HZ_NS),
    .T_SD_NS(T_SD_NS), .T_PWE_NS(T_PWE_NS), .T_SCE_NS(T_SCE_NS),
    .T_AWE_NS(T_AWE_NS), .T_WC_NS(T_WC_NS), .T_PWRUP_NS(T_PWRUP_NS)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqReady(reqReady), .stb(stb)
  );

  asram_bridge_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .memDqIn(memDqIn), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
    .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .rspValid(rspValid), .rspData(rspData)
  );

endmodule

// File: rtl/asram_host_bridge_chk.sv
module asram_host_bridge_chk #(
  parameter int ADDR_W = 17,
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqReady,
  input logic              rspValid,
  input logic              memCeN,
  input logic              memOeN,
  input logic              memWeN,
  input logic [ADDR_W-1:0] memAddr,
  input logic              memDqOe
);

  // R1 / R10: ready only in the all-high idle state
  a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (memCeN && memOeN && memWeN && !memDqOe));

  // R3: acceptance drops ready on the next cycle
  a_r3_busy_after_accept: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

  // R4: read-valid lasts a single cycle
  a_r4_single_pulse: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R5: output enable is high whenever the write strobe is low
  a_r5_oe_off_in_write: assert property (@(posedge clk) disable iff (!rstN)
    !memWeN |-> (memOeN && !memCeN));

  // R5: the write strobe rises while select is still low
  a_r5_we_ends_write: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memWeN) |-> (!memCeN && memDqOe));

  // R6: driver is off in the cycle the write strobe falls
  a_r6_turnaround: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> !memDqOe);

  // R8: no drive against the memory, no drive while deselected
  a_r8_no_contention: assert property (@(posedge clk) disable iff (!rstN)
    memDqOe |-> (memOeN && !memCeN));

  // R9: address steady while selected
  a_r9_addr_steady: assert property (@(posedge clk) disable iff (!rstN)
    (!memCeN && $past(!memCeN)) |-> $stable(memAddr));

endmodule

bind asram_host_bridge asram_host_bridge_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
  .rspValid(rspValid), .memCeN(memCeN), .memOeN(memOeN), .memWeN(memWeN),
  .memAddr(memAddr), .memDqOe(memDqOe)
);

// File: tb/asram_host_bridge_tb.sv
`timescale 1ns/1ps
module asram_host_bridge_tb;

  localparam int CLK_PERIOD = 10;
  localparam int PWR_EXP    = 100000 / CLK_PERIOD;
  // pin code {ceN, oeN, weN, dqOe}
  localparam logic [3:0] P_IDLE  = 4'b1110;
  localparam logic [3:0] P_READ  = 4'b0010;
  localparam logic [3:0] P_WTURN = 4'b0100;
  localparam logic [3:0] P_WDATA = 4'b0101;
  localparam logic [3:0] P_WHOLD = 4'b0111;

  logic clk = 1'b0;
  logic rstN;
  logic reqValid, reqReady, reqWrite, rspValid;
  logic [16:0] reqAddr, memAddr;
  logic [7:0] reqWdata, rspData, memDqOut, memDqIn;
  logic memCeN, memOeN, memWeN, memDqOe;

  int total = 0;
  int bad = 0;
  logic [7:0] mem [0:131071];

  always #(CLK_PERIOD/2) clk = ~clk;

  asram_host_bridge u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .memCeN(memCeN), .memOeN(memOeN),
    .memWeN(memWeN), .memAddr(memAddr), .memDqOut(memDqOut), .memDqOe(memDqOe),
    .memDqIn(memDqIn)
  );

  // behavioural memory
  assign memDqIn = (memCeN === 1'b0 && memOeN === 1'b0 && memWeN === 1'b1)
                   ? mem[memAddr] : 8'hEE;
  always @(posedge memWeN)
    if (memCeN === 1'b0 && memDqOe === 1'b1) mem[memAddr] <= memDqOut;

  function automatic logic [7:0] initVal(input logic [16:0] a);
    return a[7:0] ^ 8'h5A;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic logic [3:0] pins();
    return {memCeN, memOeN, memWeN, memDqOe};
  endfunction

  task automatic waitReady(output int n);
    n = 0;
    while (reqReady !== 1'b1 && n < PWR_EXP + 10) begin
      @(negedge clk);
      n++;
      if (pins() !== P_IDLE) chk(0, "R2", pins(), P_IDLE);
    end
  endtask

  task automatic doWrite(input logic [16:0] a, input logic [7:0] d);
    chk(reqReady === 1'b1, "R10", reqReady, 1);
    reqValid = 1; reqWrite = 1; reqAddr = a; reqWdata = d;
    @(negedge clk); reqValid = 0;
    chk(pins() === P_WTURN, "R5 R6 turn", pins(), P_WTURN);
    chk(reqReady === 1'b0, "R3", reqReady, 0);
    chk(memAddr === a, "R9", memAddr, a);
    @(negedge clk);
    chk(pins() === P_WDATA, "R6 R7 data", pins(), P_WDATA);
    chk(memDqOut === d, "R6", memDqOut, d);
    @(negedge clk);
    chk(pins() === P_WHOLD, "R5 R7 hold", pins(), P_WHOLD);
    chk(memAddr === a, "R9", memAddr, a);
    @(negedge clk);
    chk(pins() === P_IDLE && reqReady === 1'b1, "R10", {reqReady, pins()}, {1'b1, P_IDLE});
  endtask

  task automatic doRead(input logic [16:0] a, input logic [7:0] exp);
    chk(reqReady === 1'b1, "R10", reqReady, 1);
    reqValid = 1; reqWrite = 0; reqAddr = a;
    @(negedge clk); reqValid = 0;
    chk(pins() === P_READ, "R4 strobes", pins(), P_READ);
    chk(reqReady === 1'b0 && rspValid === 1'b0, "R3", {reqReady, rspValid}, 0);
    @(negedge clk);
    chk(rspValid === 1'b1 && rspData === exp, "R4 data", {rspValid, rspData}, {1'b1, exp});
    chk(pins() === P_IDLE && reqReady === 1'b1, "R10", {reqReady, pins()}, {1'b1, P_IDLE});
    @(negedge clk);
    chk(rspValid === 1'b0, "R4 pulse", rspValid, 0);
  endtask

  task automatic t_reset();
    rstN = 0;
    repeat (3) @(negedge clk);
    chk(pins() === P_IDLE && reqReady === 1'b0, "R1", {reqReady, pins()}, {1'b0, P_IDLE});
  endtask

  task automatic t_lockout();
    int n;
    rstN = 1;
    reqValid = 1; reqWrite = 1; reqAddr = 17'h00005; reqWdata = 8'hAA;
    repeat (3) @(negedge clk);
    reqValid = 0;
    chk(reqReady === 1'b0, "R2 early", reqReady, 0);
    waitReady(n);
    chk(n + 3 == PWR_EXP, "R2 length", n + 3, PWR_EXP);
    doRead(17'h00005, initVal(17'h00005));
  endtask

  task automatic t_write_read();
    doWrite(17'h1ABCD, 8'h3C);
    doRead(17'h1ABCD, 8'h3C);
    doWrite(17'h00000, 8'hFF);
    doWrite(17'h1FFFF, 8'h00);
    doRead(17'h00000, 8'hFF);
    doRead(17'h1FFFF, 8'h00);
    doRead(17'h00777, initVal(17'h00777));
  endtask

  task automatic t_busy_ignore();
    chk(reqReady === 1'b1, "R3", reqReady, 1);
    reqValid = 1; reqWrite = 1; reqAddr = 17'h00100; reqWdata = 8'h11;
    @(negedge clk);
    reqAddr = 17'h00200; reqWdata = 8'h99;
    @(negedge clk);
    chk(reqReady === 1'b0, "R3 busy", reqReady, 0);
    chk(memAddr === 17'h00100, "R3 R9", memAddr, 17'h00100);
    @(negedge clk);
    chk(memDqOut === 8'h11, "R3 data", memDqOut, 8'h11);
    reqValid = 0;
    @(negedge clk);
    doRead(17'h00200, initVal(17'h00200));
    doRead(17'h00100, 8'h11);
  endtask

  task automatic t_reset_mid();
    int n;
    reqValid = 1; reqWrite = 1; reqAddr = 17'h00300; reqWdata = 8'h77;
    @(negedge clk); reqValid = 0;
    chk(pins() === P_WTURN, "R11 started", pins(), P_WTURN);
    rstN = 0;
    #1;
    chk(pins() === P_IDLE && reqReady === 1'b0, "R11 abort", {reqReady, pins()}, {1'b0, P_IDLE});
    @(negedge clk);
    rstN = 1;
    waitReady(n);
    chk(n == PWR_EXP, "R11 relock", n, PWR_EXP);
    doRead(17'h00300, initVal(17'h00300));
  endtask

  initial begin
    for (int i = 0; i < 131072; i++) mem[i] = initVal(17'(i));
    rstN = 0; reqValid = 0; reqWrite = 0; reqAddr = '0; reqWdata = '0;
    t_reset();
    t_lockout();
    t_write_read();
    t_busy_ignore();
    t_reset_mid();
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule